// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the shifting datapath of a 32-bit integer execution stage. In one registered cycle it shifts a word left, shifts it right with zero fill or sign fill, or rotates it left or right. The amount comes from one of two places. The first is the low bits of a second register operand. The second is a 5-bit immediate field. A 3-bit operation select picks the function.

A shift whose amount comes from the register uses six amount bits. Amounts from 32 to 63 are therefore legal and move every bit out of the word. Rotates with a register amount, and every operation with an immediate amount, use only five bits. A rotation is therefore always between 0 and 31 places. The issue logic presents one operation per cycle with a valid strobe, and the result appears on the next cycle with its own valid strobe.

Top module: `shrot_unit`

## Requirements
- R1: In reset, `out_valid` and `result` are 0. `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R2: With `op_sel` = 3'b000 (shift left), the result is the operand moved toward bit 31 by the amount, and the vacated low bits are 0.
- R3: With `op_sel` = 3'b001 (logical shift right), the result is the operand moved toward bit 0 by the amount, and the vacated high bits are 0.
- R4: With `op_sel` = 3'b010 (arithmetic shift right), the result is the operand moved toward bit 0, and the vacated high bits are copies of the original bit 31.
- R5: With `amt_src` = 0 (register amount), the three shifts use `amt_reg[5:0]` and ignore `amt_reg[31:6]`. For an amount of 32 to 63, shift left and logical shift right give 0, and arithmetic shift right gives 32 copies of operand bit 31.
- R6: With `amt_src` = 1 (immediate amount), every operation uses `amt_imm[4:0]` as its amount, and `amt_reg` has no effect.
- R7: `op_sel` = 3'b011 rotates left and 3'b100 rotates right. Bits leave one end of the word and re-enter at the other end. With a register amount, only `amt_reg[4:0]` is used, so `amt_reg[5]` has no effect on a rotate.
- R8: A shift or rotate by an effective amount of 0 returns the operand unchanged.
- R9: `op_sel` codes 3'b101, 3'b110 and 3'b111 return the operand unchanged, whatever the amount.
- R10: While `in_valid` is low, `result` keeps the last value it registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation: 0 shl, 1 shr, 2 shrs, 3 rotl, 4 rotr, 5-7 pass |
| amt_src | input | 1 | 0: amount from amt_reg, 1: amount from amt_imm |
| operand | input | 32 | Word to shift or rotate |
| amt_reg | input | 32 | Second register operand; low bits give the amount |
| amt_imm | input | 5 | Immediate amount field |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Registered result |

## Verification
The assertions compare the registered result against the inputs sampled on the previous edge. They therefore assume that `op_sel`, `amt_src` and the data inputs are known whenever `in_valid` is high. The stimulus changes inputs only on the falling clock edge and never leaves a valid cycle with undriven fields.

The stimulus covers amounts of 0, 1, 31, 32 and 63, plus register values with junk above bit 5. It sends operands with bit 31 set and clear, and includes every unused op code. It also inserts idle cycles, so that the hold behaviour in R10 is observed at the result port.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    parameter int unsigned WORD_W = 32;
    localparam int unsigned AMT_W = $clog2(WORD_W);

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SHRS = 3'd2,
        OP_ROTL = 3'd3,
        OP_ROTR = 3'd4
    } shrot_op_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] result;
    } shrot_state_t;
endpackage

// File: rtl/shrot_amount.sv
module shrot_amount
    import shrot_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [2:0]    op_sel,
    input  logic          amt_src,
    input  logic [W-1:0]  amt_reg,
    input  logic [AW-1:0] amt_imm,
    output logic [AW-1:0] amt_eff,
    output logic [AW-1:0] rr_amt,
    output logic          beyond
);
    logic is_shift;
    logic goes_left;

    always_comb begin
        is_shift  = (op_sel == OP_SHL) || (op_sel == OP_SHR) || (op_sel == OP_SHRS);
        goes_left = (op_sel == OP_SHL) || (op_sel == OP_ROTL);
        if (amt_src) begin
            amt_eff = amt_imm;
            beyond  = 1'b0;
        end else begin
            amt_eff = amt_reg[AW-1:0];
            beyond  = is_shift & amt_reg[AW];
        end
        // A left move by n equals a right rotation by (W - n) mod W.
        rr_amt = goes_left ? (AW'(0) - amt_eff) : amt_eff;
    end
endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [AW:0][W-1:0] stage;

    assign stage[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][STEP-1:0], stage[s][W-1:STEP]} : stage[s];
    end

    assign dout = stage[AW];
endmodule

// File: rtl/shrot_mask.sv
module shrot_mask #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [AW-1:0] amt,
    input  logic          left,
    output logic [W-1:0]  keep
);
    logic [AW:0][W-1:0] stage;
    logic [W-1:0]       flipped;

    assign stage[0] = {W{1'b1}};

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        assign stage[s+1] = amt[s] ? (stage[s] >> STEP) : stage[s];
    end

    for (genvar b = 0; b < W; b++) begin : g_flip
        assign flipped[b] = stage[AW][W-1-b];
    end

    assign keep = left ? flipped : stage[AW];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              amt_src,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [4:0]        amt_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned AW = $clog2(DATA_W);

    shrot_state_t state_d, state_q;

    logic [AW-1:0]     amt_eff;
    logic [AW-1:0]     rr_amt;
    logic              beyond;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] fill;
    logic [DATA_W-1:0] value;

    shrot_amount #(.W(DATA_W), .AW(AW)) u_amount (
        .op_sel (op_sel),
        .amt_src(amt_src),
        .amt_reg(amt_reg),
        .amt_imm(amt_imm[AW-1:0]),
        .amt_eff(amt_eff),
        .rr_amt (rr_amt),
        .beyond (beyond)
    );

    shrot_rotator #(.W(DATA_W), .AW(AW)) u_rotator (
        .din (operand),
        .amt (rr_amt),
        .dout(rotated)
    );

    shrot_mask #(.W(DATA_W), .AW(AW)) u_mask (
        .amt (amt_eff),
        .left(op_sel == OP_SHL),
        .keep(keep)
    );

    always_comb begin
        fill = (op_sel == OP_SHRS) ? {DATA_W{operand[DATA_W-1]}} : '0;
        unique case (op_sel)
            OP_SHL, OP_SHR, OP_SHRS:
                value = beyond ? fill : ((rotated & keep) | (fill & ~keep));
            OP_ROTL, OP_ROTR:
                value = rotated;
            default:
                value = operand;
        endcase
        state_d.valid  = in_valid;
        state_d.result = in_valid ? value : state_q.result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.result;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R10
    AST_LOGIC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !amt_src && amt_reg[5] && (op_sel == 3'd0 || op_sel == 3'd1)
        |=> result == '0); // R5
    AST_SIGN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !amt_src && amt_reg[5] && op_sel == 3'd2
        |=> result == {DATA_W{$past(operand[DATA_W-1])}}); // R5
    AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_sel > 3'd4 |=> result == $past(operand)); // R9
    AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_sel < 3'd5 &&
        (amt_src ? (amt_imm == 5'd0)
                 : ((op_sel > 3'd2) ? (amt_reg[4:0] == 5'd0) : (amt_reg[5:0] == 6'd0)))
        |=> result == $past(operand)); // R8
    AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_sel == 3'd3 || op_sel == 3'd4)
        |=> $countones(result) == $countones($past(operand))); // R7
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        amt_src = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] amt_reg = '0;
    logic [4:0]  amt_imm = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    shrot_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .amt_src(amt_src), .operand(operand), .amt_reg(amt_reg),
        .amt_imm(amt_imm), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model(input logic [2:0] op, input logic src,
                                          input logic [31:0] a, input logic [31:0] r,
                                          input logic [4:0] i);
        int n;
        n = src ? int'(i) : ((op == 3'd3 || op == 3'd4) ? int'(r[4:0]) : int'(r[5:0]));
        case (op)
            3'd0: return (n >= 32) ? 32'd0 : (a << n);
            3'd1: return (n >= 32) ? 32'd0 : (a >> n);
            3'd2: return (n >= 32) ? {32{a[31]}} : 32'($signed(a) >>> n);
            3'd3: return (n == 0) ? a : ((a << n) | (a >> (32 - n)));
            3'd4: return (n == 0) ? a : ((a >> n) | (a << (32 - n)));
            default: return a;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [2:0] op, input logic src,
                         input logic [31:0] a, input logic [31:0] r, input logic [4:0] i);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; amt_src = src;
        operand = a; amt_reg = r; amt_imm = i;
        it.exp = model(op, src, a, r, i);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand  = 32'hDEAD_BEEF;
            amt_reg  = 32'h0000_0007;
            op_sel   = 3'd0;
        end
    endtask

    // Monitor: pops one expected item for every valid result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected out_valid", {31'd0, out_valid}, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, result, it.exp);
            end
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] last;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset result", result, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive("R2 shl reg 4", 3'd0, 1'b0, 32'h8000_00F1, 32'd4, 5'd0);
        drive("R2 shl reg 31", 3'd0, 1'b0, 32'h0000_0003, 32'd31, 5'd0);
        drive("R3 shr reg 8", 3'd1, 1'b0, 32'hF234_5678, 32'd8, 5'd0);
        drive("R3 shr reg 31", 3'd1, 1'b0, 32'h8000_0000, 32'd31, 5'd0);
        drive("R4 shrs neg 4", 3'd2, 1'b0, 32'h8765_4321, 32'd4, 5'd0);
        drive("R4 shrs pos 4", 3'd2, 1'b0, 32'h7765_4321, 32'd4, 5'd0);
        drive("R5 shl reg 32", 3'd0, 1'b0, 32'hFFFF_FFFF, 32'd32, 5'd0);
        drive("R5 shr reg 63", 3'd1, 1'b0, 32'hFFFF_FFFF, 32'd63, 5'd0);
        drive("R5 shrs neg 40", 3'd2, 1'b0, 32'h8000_0001, 32'd40, 5'd0);
        drive("R5 shrs pos 33", 3'd2, 1'b0, 32'h7FFF_FFFF, 32'd33, 5'd0);
        drive("R5 high bits ignored", 3'd0, 1'b0, 32'h0000_00FF, 32'hABCD_EF03, 5'd0);
        drive("R6 shl imm 12", 3'd0, 1'b1, 32'h0001_2345, 32'd40, 5'd12);
        drive("R6 shrs imm 31", 3'd2, 1'b1, 32'h8000_0000, 32'd0, 5'd31);
        drive("R6 rotr imm 8", 3'd4, 1'b1, 32'h1234_5678, 32'd3, 5'd8);
        drive("R7 rotl reg 4", 3'd3, 1'b0, 32'hF000_000A, 32'd4, 5'd0);
        drive("R7 rotr reg 1", 3'd4, 1'b0, 32'h0000_0001, 32'd1, 5'd0);
        drive("R7 rotl bit5 ignored", 3'd3, 1'b0, 32'h1234_5678, 32'd36, 5'd0);
        drive("R7 rotr 31", 3'd4, 1'b0, 32'h8000_0001, 32'd31, 5'd0);
        drive("R8 shr zero", 3'd1, 1'b0, 32'hCAFE_F00D, 32'd0, 5'd0);
        drive("R8 rotl 32 is zero", 3'd3, 1'b0, 32'hCAFE_F00D, 32'd32, 5'd0);
        drive("R8 shrs imm zero", 3'd2, 1'b1, 32'h8000_0000, 32'd9, 5'd0);
        drive("R9 op5", 3'd5, 1'b0, 32'h0BAD_CAFE, 32'd7, 5'd3);
        drive("R9 op6", 3'd6, 1'b1, 32'h0BAD_CAFE, 32'd7, 5'd3);
        drive("R9 op7", 3'd7, 1'b0, 32'h1357_9BDF, 32'd33, 5'd1);
        drive("R10 last value", 3'd0, 1'b1, 32'h0000_0001, 32'd0, 5'd20);
        last = 32'h0010_0000;
        idle(1);
        check("R1 valid after last", {31'd0, out_valid}, 32'd1);
        idle(3);
        check("R1 valid low when idle", {31'd0, out_valid}, 32'd0);
        check("R10 result held", result, last);
        for (int n = 0; n < 64; n += 7) begin
            drive("R5 sweep shr", 3'd1, 1'b0, 32'hA5A5_5A5A, 32'(n), 5'd0);
            drive("R4 sweep shrs", 3'd2, 1'b0, 32'hA5A5_5A5A, 32'(n), 5'd0);
            drive("R7 sweep rotl", 3'd3, 1'b0, 32'hA5A5_5A5A, 32'(n), 5'd0);
        end
        idle(3);
        check("R1 queue drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule